// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block takes each new 12-bit two's-complement temperature result and compares it against a high limit and a low limit. It counts consecutive faulting conversions against a programmable queue depth. Only when that count is reached does the thermostat change state, so a single noisy sample cannot flip the output. The two limits give hysteresis. A trip needs the temperature at or above the high limit. The return needs it strictly below the low limit.

Two output behaviours are offered. In comparator mode the alert output follows the tripped state directly. In interrupt mode every change of the tripped state raises a pending alert. That alert is held until software reads any register, until the device wins an SMBus alert response, or until shutdown is entered. A polarity setting inverts both the alert pin and the status bit that software reads. The block also supplies the cause bit that goes back during an alert response. A general-call reset clears all internal state.

Top module: `thermo_alert`

## Requirements
- R1: The depth code `depth_sel` selects how many consecutive faulting conversions change the state: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4, 2'b11 needs 6.
- R2: While not tripped, a conversion faults when the signed temperature is greater than or equal to `lim_high`. While tripped, it faults only when the signed temperature is strictly less than `lim_low`.
- R3: A conversion that does not fault sets the consecutive count back to zero.
- R4: The tripped state changes only in a cycle where `new_result` is high. With `interrupt_mode`=0, the asserted alert equals the tripped state.
- R5: With `interrupt_mode`=1, every change of the tripped state sets a pending alert, and the asserted alert equals that pending flag. The flag is cleared by `clr_read`, by `clr_response`, or by a rising edge of `shutdown`. If a state change and a clear fall in the same cycle, the set wins.
- R6: `alert_n_pin` is low while the alert is asserted when `alert_pol`=0. With `alert_pol`=1 the pin is inverted.
- R7: `os_status` is the inverse of the tripped state when `alert_pol`=0, and equals it when `alert_pol`=1, whatever the mode. After reset it reads 1 with `alert_pol`=0.
- R8: `gc_reset` clears the tripped state, the consecutive count, the pending alert and the cause, and it takes priority over `new_result`.
- R9: `resp_cause` is 0 when the last state change was a high trip and 1 when it was a low return, XORed with `alert_pol`. It reads as `alert_pol` after reset.
- R10: All 12 bits of the temperature and of both limits take part in the comparison, including the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| new_result | input | 1 | One-cycle pulse: `temp` holds a fresh conversion |
| temp | input | 12 | Conversion result, two's complement |
| lim_high | input | 12 | High limit, two's complement |
| lim_low | input | 12 | Low limit, two's complement |
| depth_sel | input | 2 | Consecutive-fault depth code |
| interrupt_mode | input | 1 | 0 comparator, 1 interrupt |
| alert_pol | input | 1 | 0 active-low pin, 1 active-high pin |
| shutdown | input | 1 | Shutdown setting; rising edge clears pending alert |
| clr_read | input | 1 | Pulse: any register was read |
| clr_response | input | 1 | Pulse: alert response won by this device |
| gc_reset | input | 1 | Pulse: general-call reset |
| alert_n_pin | output | 1 | Alert pin level |
| os_status | output | 1 | Thermostat status bit as read by software |
| resp_cause | output | 1 | Cause bit returned during alert response |

## Verification
The bench targets the limit equalities. A temperature exactly equal to the high limit must trip, and one exactly equal to the low limit must not return. A design that swaps `>=` and `>` would trip late or return early. It mixes signed limits with results of opposite sign, where an unsigned compare trips on the wrong side of zero. It also interrupts a partial fault run with one clean sample; a counter that does not restart would trip too soon. In interrupt mode it lands a state change and a read clear in the same cycle, where a clear-first design would lose the alert. Further cases are a one-LSB difference in the limit, a general-call reset in the middle of a run, and the cause bit under both polarities.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

    localparam int TEMP_W = 12;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        QD_ONE  = 2'b00,
        QD_TWO  = 2'b01,
        QD_FOUR = 2'b10,
        QD_SIX  = 2'b11
    } qdepth_e;

    typedef struct packed {
        logic             tripped;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             cause_low;
        logic             sd_seen;
    } ta_state_t;

endpackage

// File: rtl/ta_compare.sv
module ta_compare #(
    parameter int W = 12
) (
    input  logic [W-1:0] temp,
    input  logic [W-1:0] lim_high,
    input  logic [W-1:0] lim_low,
    output logic         at_or_above_high,
    output logic         below_low
);
    always_comb begin
        at_or_above_high = $signed(temp) >= $signed(lim_high);
        below_low        = $signed(temp) <  $signed(lim_low);
    end
endmodule

// File: rtl/ta_depth.sv
module ta_depth
    import thermo_alert_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [1:0]    depth_sel,
    output logic [CW-1:0] need
);
    always_comb begin
        unique case (qdepth_e'(depth_sel))
            QD_ONE:  need = CW'(1);
            QD_TWO:  need = CW'(2);
            QD_FOUR: need = CW'(4);
            default: need = CW'(6);
        endcase
    end
endmodule

// File: rtl/ta_outputs.sv
module ta_outputs (
    input  logic tripped,
    input  logic pend,
    input  logic cause_low,
    input  logic interrupt_mode,
    input  logic alert_pol,
    output logic alert_n_pin,
    output logic os_status,
    output logic resp_cause
);
    logic asserted;
    always_comb begin
        asserted    = interrupt_mode ? pend : tripped;
        alert_n_pin = alert_pol ? asserted : ~asserted;
        os_status   = alert_pol ? tripped : ~tripped;
        resp_cause  = cause_low ^ alert_pol;
    end
endmodule

// File: rtl/thermo_alert.sv
module thermo_alert
    import thermo_alert_pkg::*;
#(
    parameter int TW = TEMP_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          new_result,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_high,
    input  logic [TW-1:0] lim_low,
    input  logic [1:0]    depth_sel,
    input  logic          interrupt_mode,
    input  logic          alert_pol,
    input  logic          shutdown,
    input  logic          clr_read,
    input  logic          clr_response,
    input  logic          gc_reset,
    output logic          alert_n_pin,
    output logic          os_status,
    output logic          resp_cause
);
    ta_state_t     s_d, s_q;
    logic          above_high, below_low;
    logic [CW-1:0] need;
    logic [CW-1:0] cnt_inc;
    logic          fault, flip;

    ta_compare #(.W(TW)) u_cmp (
        .temp(temp), .lim_high(lim_high), .lim_low(lim_low),
        .at_or_above_high(above_high), .below_low(below_low)
    );

    ta_depth #(.CW(CW)) u_depth (
        .depth_sel(depth_sel), .need(need)
    );

    ta_outputs u_out (
        .tripped(s_q.tripped), .pend(s_q.pend), .cause_low(s_q.cause_low),
        .interrupt_mode(interrupt_mode), .alert_pol(alert_pol),
        .alert_n_pin(alert_n_pin), .os_status(os_status), .resp_cause(resp_cause)
    );

    // Next-state computation: fault filter, hysteresis and pending alert
    always_comb begin
        s_d     = s_q;
        flip    = 1'b0;
        fault   = s_q.tripped ? below_low : above_high;
        cnt_inc = s_q.cnt + 1'b1;
        if (gc_reset) begin
            s_d         = '0;
            s_d.sd_seen = shutdown;
        end else begin
            if (new_result) begin
                if (fault) begin
                    if (cnt_inc >= need) begin
                        flip  = 1'b1;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end else begin
                    s_d.cnt = '0;
                end
            end
            if (flip) begin
                s_d.tripped   = ~s_q.tripped;
                s_d.cause_low = s_q.tripped;
                s_d.pend      = 1'b1;
            end else if (clr_read || clr_response || (shutdown && !s_q.sd_seen)) begin
                s_d.pend = 1'b0;
            end
            s_d.sd_seen = shutdown;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk (
    input logic clk,
    input logic rst_n,
    input logic new_result,
    input logic interrupt_mode,
    input logic alert_pol,
    input logic clr_read,
    input logic gc_reset,
    input logic alert_n_pin,
    input logic os_status,
    input logic resp_cause
);
    AST_CMP_PIN_MATCHES_OS: assert property (@(posedge clk) disable iff (!rst_n)
        !interrupt_mode |-> (alert_n_pin == os_status)); // R6

    AST_STATE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_result && !gc_reset) |=> (!$stable(alert_pol) || $stable(os_status))); // R4

    AST_GC_CLEARS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (os_status == !alert_pol)); // R8

    AST_READ_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_read && !new_result) |=> (!interrupt_mode || alert_n_pin == !alert_pol)); // R5

    AST_GC_CAUSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (resp_cause == alert_pol)); // R9
endmodule

bind thermo_alert thermo_alert_chk u_thermo_alert_chk (
    .clk(clk), .rst_n(rst_n), .new_result(new_result),
    .interrupt_mode(interrupt_mode), .alert_pol(alert_pol),
    .clr_read(clr_read), .gc_reset(gc_reset),
    .alert_n_pin(alert_n_pin), .os_status(os_status), .resp_cause(resp_cause)
);

// File: tb/test_thermo_alert.sv
module test_thermo_alert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_result = 1'b0;
    logic [11:0] temp = '0;
    logic [11:0] lim_high = 12'h500;
    logic [11:0] lim_low = 12'h4B0;
    logic [1:0]  depth_sel = 2'b00;
    logic        interrupt_mode = 1'b0;
    logic        alert_pol = 1'b0;
    logic        shutdown = 1'b0;
    logic        clr_read = 1'b0;
    logic        clr_response = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_n_pin, os_status, resp_cause;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    thermo_alert i_thermo_alert (
        .clk(clk), .rst_n(rst_n), .new_result(new_result), .temp(temp),
        .lim_high(lim_high), .lim_low(lim_low), .depth_sel(depth_sel),
        .interrupt_mode(interrupt_mode), .alert_pol(alert_pol),
        .shutdown(shutdown), .clr_read(clr_read), .clr_response(clr_response),
        .gc_reset(gc_reset), .alert_n_pin(alert_n_pin), .os_status(os_status),
        .resp_cause(resp_cause)
    );

    // Behavioural reference model
    int m_cnt;
    bit m_trip, m_pend, m_cause, m_sdprev;

    function automatic int sx(logic [11:0] v);
        return v[11] ? int'(v) - 4096 : int'(v);
    endfunction

    function automatic int need_of(logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 6;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_trip = 0; m_pend = 0; m_cause = 0; m_sdprev = 0;
        end else if (gc_reset) begin
            m_cnt = 0; m_trip = 0; m_pend = 0; m_cause = 0; m_sdprev = shutdown;
        end else begin
            bit changed;
            bit f;
            changed = 0;
            if (new_result) begin
                f = m_trip ? (sx(temp) < sx(lim_low)) : (sx(temp) >= sx(lim_high));
                if (f) begin
                    m_cnt++;
                    if (m_cnt >= need_of(depth_sel)) begin
                        m_cause = m_trip;
                        m_trip = !m_trip;
                        m_cnt = 0;
                        changed = 1;
                    end
                end else m_cnt = 0;
            end
            if (changed) m_pend = 1;
            else if (clr_read || clr_response || (shutdown && !m_sdprev)) m_pend = 0;
            m_sdprev = shutdown;
        end
    end

    always @(negedge clk) begin
        bit act, e_pin, e_os, e_rc;
        act   = interrupt_mode ? m_pend : m_trip;
        e_pin = alert_pol ? act : !act;
        e_os  = alert_pol ? m_trip : !m_trip;
        e_rc  = m_cause ^ alert_pol;
        tests++;
        if (alert_n_pin !== e_pin || os_status !== e_os || resp_cause !== e_rc) begin
            fails++;
            $display("FAIL R4/R5/R6/R7/R9 model compare: pin=%b os=%b rc=%b expected %b %b %b",
                     alert_n_pin, os_status, resp_cause, e_pin, e_os, e_rc);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic conv(input logic [11:0] t);
        @(negedge clk);
        temp = t; new_result = 1'b1;
        @(negedge clk);
        new_result = 1'b0;
    endtask

    task automatic pulse_read;
        @(negedge clk); clr_read = 1'b1;
        @(negedge clk); clr_read = 1'b0;
    endtask

    task automatic pulse_gc;
        @(negedge clk); gc_reset = 1'b1;
        @(negedge clk); gc_reset = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 os after reset", os_status, 1'b1);
        chk("R6 pin after reset", alert_n_pin, 1'b1);
        chk("R9 cause after reset", resp_cause, 1'b0);

        // R2 equality on high limit, strict low limit
        conv(12'h500);
        chk("R2 temp equal high trips", os_status, 1'b0);
        chk("R4 comparator pin", alert_n_pin, 1'b0);
        conv(12'h4B0);
        chk("R2 temp equal low holds", os_status, 1'b0);
        conv(12'h4AF);
        chk("R2 below low returns", os_status, 1'b1);

        // R4 no change without new_result
        @(negedge clk); temp = 12'h600;
        repeat (3) @(negedge clk);
        chk("R4 idle no change", os_status, 1'b1);

        // R3 and R1 depth four
        depth_sel = 2'b10;
        for (int i = 0; i < 3; i++) conv(12'h500);
        conv(12'h490);
        for (int i = 0; i < 3; i++) conv(12'h500);
        chk("R3 run broken restarts", os_status, 1'b1);
        conv(12'h500);
        chk("R1 depth four trips", os_status, 1'b0);

        // R1 depth six return
        depth_sel = 2'b11;
        for (int i = 0; i < 5; i++) conv(12'h400);
        chk("R1 five of six holds", os_status, 1'b0);
        conv(12'h400);
        chk("R1 depth six returns", os_status, 1'b1);

        // R1 depth two
        depth_sel = 2'b01;
        conv(12'h500);
        chk("R1 one of two holds", os_status, 1'b1);
        conv(12'h500);
        chk("R1 depth two trips", os_status, 1'b0);
        conv(12'h400); conv(12'h400);
        depth_sel = 2'b00;

        // R2 signed comparison
        lim_high = 12'hFFC; lim_low = 12'hF00;
        conv(12'h000);
        chk("R2 signed zero above -0.25", os_status, 1'b0);
        conv(12'hF00);
        chk("R2 signed equal low holds", os_status, 1'b0);
        conv(12'h800);
        chk("R2 signed -128 returns", os_status, 1'b1);

        // R10 LSB of limit matters
        lim_high = 12'h501; lim_low = 12'h4B0;
        conv(12'h500);
        chk("R10 one LSB below high", os_status, 1'b1);
        conv(12'h501);
        chk("R10 equal full width", os_status, 1'b0);
        conv(12'h4AF);
        lim_high = 12'h500;

        // R5 interrupt mode
        interrupt_mode = 1'b1;
        pulse_read;
        chk("R5 read clears stale", alert_n_pin, 1'b1);
        conv(12'h500);
        chk("R5 high trip asserts", alert_n_pin, 1'b0);
        chk("R9 cause high", resp_cause, 1'b0);
        pulse_read;
        chk("R5 read clears", alert_n_pin, 1'b1);
        conv(12'h600);
        chk("R5 no change no alert", alert_n_pin, 1'b1);
        chk("R7 os independent of mode", os_status, 1'b0);
        conv(12'h400);
        chk("R5 low return asserts", alert_n_pin, 1'b0);
        chk("R9 cause low", resp_cause, 1'b1);
        @(negedge clk); clr_response = 1'b1;
        @(negedge clk); clr_response = 1'b0;
        chk("R5 response clears", alert_n_pin, 1'b1);
        conv(12'h500);
        @(negedge clk); shutdown = 1'b1;
        @(negedge clk);
        chk("R5 shutdown entry clears", alert_n_pin, 1'b1);
        shutdown = 1'b0;
        @(negedge clk);
        temp = 12'h400; new_result = 1'b1; clr_read = 1'b1;
        @(negedge clk);
        new_result = 1'b0; clr_read = 1'b0;
        chk("R5 set wins over clear", alert_n_pin, 1'b0);

        // R6 R7 R9 polarity inverted
        alert_pol = 1'b1;
        @(negedge clk);
        chk("R6 pin inverted", alert_n_pin, 1'b1);
        chk("R7 os inverted", os_status, 1'b0);
        chk("R9 cause inverted", resp_cause, 1'b0);

        // R8 general-call reset
        alert_pol = 1'b0; interrupt_mode = 1'b0;
        conv(12'h500);
        chk("R8 tripped before gc", os_status, 1'b0);
        pulse_gc;
        chk("R8 gc clears trip", os_status, 1'b1);
        chk("R8 gc clears cause", resp_cause, 1'b0);
        depth_sel = 2'b01;
        conv(12'h500);
        pulse_gc;
        conv(12'h500);
        chk("R8 gc clears count", os_status, 1'b1);
        conv(12'h500);
        chk("R8 run after gc trips", os_status, 1'b0);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule